// File: doc/BRIEF.md
# Serial display-memory slave with command decoding

This block sits behind a four-wire host link made of an active-low select, a write strobe, a read strobe and one bidirectional data line. Every pin is resampled by the block's own faster clock, and the block acts only on the edges that it detects. At the start of a session the host sends a three-bit mode code. The block then does one of three things. It streams four-bit nibbles into or out of a small display memory, starting at a six-bit address that auto-increments. It lets the host read a nibble and rewrite the same location. Or it accepts back-to-back nine-bit command words.

Each complete command word is emitted as a one-cycle strobe that carries the raw word. The same cycle also raises a decoded event for the few command families that the surrounding display logic acts on. A separate asynchronous read port lets a panel scanner fetch any nibble at any time without disturbing the host link.

Top module: `lcd_serial_slave`

## Requirements
- R1: The first three bits after select goes low are the mode code, first bit first: 110 selects read, 101 selects write (with interleaved reads), 100 selects commands. Any other code makes the block ignore the rest of that session, with no memory write and no command strobe.
- R2: A bit on `sdin` is taken only on a rising edge of `wclk`. Levels and falling edges of `wclk` capture nothing.
- R3: In the data modes a 6-bit address follows the mode code, most significant bit first. Each nibble follows after it, least significant bit first. The nibble is written when its fourth bit arrives.
- R4: After each nibble the address advances by one. Address 31 advances to 0, and so does address 63.
- R5: Writes to addresses 32 to 63 leave the memory unchanged. Reads from those addresses return zero.
- R6: In read mode each falling edge of `rclk` drives the next bit of the nibble at the current address on `sdata_out`, least significant bit first. The address advances after the fourth bit.
- R7: In write mode, falling edges of `rclk` shift out the nibble at the current address without moving the address. The next written nibble goes to that same address, and the address then advances.
- R8: In command mode each command word is 9 bits, bit 8 first. Each completed word raises `cmd_stb` for one cycle with the word on `cmd_word`. Further words follow without a new mode code.
- R9: Decoded events come with `cmd_stb`, at most one per word, using word bits [8:1]. The events are 0000_0000 system off, 0000_0001 system on, 0000_0010 display off, 0000_0011 display on, 0000_1000 tone off and 0000_1001 tone on. A word with bits [8:5]=0010 is a bias event, with `com_code`=bits[4:3] and `bias_third`=bit 1. A word with bits [8:6]=101 is a rate event, with `rate_code`=bits[3:1]. All other words raise no event.
- R10: A high level on `sel_n` drops any partial address, nibble or command word. After select returns low, a new mode code is expected.
- R11: `sdata_oe` rises on an `rclk` falling edge in the data phase. It falls on the next `wclk` edge of either polarity, or when `sel_n` goes high. It is low after reset.
- R12: Reset clears the memory to zero. `scan_data` always shows the nibble at `scan_addr`, with zero for an address of 32 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Session select, active low |
| wclk | input | 1 | Host write strobe |
| rclk | input | 1 | Host read strobe |
| sdin | input | 1 | Data line as seen by the block |
| sdata_out | output | 1 | Bit driven towards the host |
| sdata_oe | output | 1 | Drive enable for the data line |
| scan_addr | input | 6 | Scanner read address |
| scan_data | output | 4 | Scanner read nibble |
| cmd_stb | output | 1 | One-cycle pulse per command word |
| cmd_word | output | 9 | Last completed command word |
| evt_sys_off | output | 1 | System-off command seen |
| evt_sys_on | output | 1 | System-on command seen |
| evt_lcd_off | output | 1 | Display-off command seen |
| evt_lcd_on | output | 1 | Display-on command seen |
| evt_tone_off | output | 1 | Tone-off command seen |
| evt_tone_on | output | 1 | Tone-on command seen |
| evt_bias | output | 1 | Bias and common-count command seen |
| evt_rate | output | 1 | Rate-select command seen |
| com_code | output | 2 | Common-count field of the bias command |
| bias_third | output | 1 | Bias field of the bias command |
| rate_code | output | 3 | Field of the rate command |

## Verification
The bench builds the block with its default parameters: 6 address bits, 32 nibbles of 4 bits, and two synchronizer stages. Because the memory covers only half of the 6-bit address space, short bursts are enough to reach the 31-to-0 wrap, the ignored writes above 31 and the zero read-back. The two-stage synchronizer puts edge detection about three cycles behind a pin change, so the bench holds each strobe level for five cycles and samples in the quiet half of the clock. A scoreboard queue of command words, together with a bench-side memory model, checks every command strobe, decoded field and scanner read.

// File: rtl/lcdsi_pkg.sv
package lcdsi_pkg;
  localparam int CMD_BITS = 9;
  localparam int MODE_BITS = 3;

  localparam logic [MODE_BITS-1:0] MODE_RD  = 3'b110;
  localparam logic [MODE_BITS-1:0] MODE_WR  = 3'b101;
  localparam logic [MODE_BITS-1:0] MODE_CMD = 3'b100;

  typedef enum logic [2:0] {
    PH_ID,
    PH_ADDR,
    PH_DATA,
    PH_CMD,
    PH_DEAD
  } phase_t;

  typedef struct packed {
    logic sys_off;
    logic sys_on;
    logic lcd_off;
    logic lcd_on;
    logic tone_off;
    logic tone_on;
    logic bias;
    logic rate;
  } cmd_evt_t;

  // Classify one command word; upper eight bits select fixed opcodes.
  function automatic cmd_evt_t classify(input logic [CMD_BITS-1:0] w);
    cmd_evt_t e;
    logic [7:0] op;
    op = w[CMD_BITS-1:1];
    e = '0;
    e.sys_off  = (op == 8'h00);
    e.sys_on   = (op == 8'h01);
    e.lcd_off  = (op == 8'h02);
    e.lcd_on   = (op == 8'h03);
    e.tone_off = (op == 8'h08);
    e.tone_on  = (op == 8'h09);
    e.bias     = (w[8:5] == 4'b0010);
    e.rate     = (w[8:6] == 3'b101);
    return e;
  endfunction
endpackage

// File: rtl/lcdsi_pin_sync.sv
module lcdsi_pin_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [STAGES:0][W-1:0] pipe;
  logic [W-1:0] prev;

  assign pipe[0] = pins;

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= RST_VAL;
      else        pipe[g] <= pipe[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= pipe[STAGES];
  end

  assign lvl  = pipe[STAGES];
  assign rise = pipe[STAGES] & ~prev;
  assign fall = ~pipe[STAGES] & prev;
endmodule

// File: rtl/lcdsi_ram.sv
module lcdsi_ram #(
  parameter int ADDR_W = 6,
  parameter int DEPTH = 32,
  parameter int NIB_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [NIB_W-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [NIB_W-1:0]  rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [NIB_W-1:0]  rdata_b
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [NIB_W-1:0] mem [DEPTH];

  function automatic logic in_range(input logic [ADDR_W-1:0] a);
    return int'(a) < DEPTH;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && in_range(waddr)) begin
      mem[waddr[IDX_W-1:0]] <= wdata;
    end
  end

  assign rdata_a = in_range(raddr_a) ? mem[raddr_a[IDX_W-1:0]] : '0;
  assign rdata_b = in_range(raddr_b) ? mem[raddr_b[IDX_W-1:0]] : '0;
endmodule

// File: rtl/lcdsi_engine.sv
module lcdsi_engine
  import lcdsi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DEPTH = 32,
  parameter int NIB_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_act,
  input  logic                din,
  input  logic                wr_rise,
  input  logic                wr_edge,
  input  logic                rd_fall,
  input  logic [NIB_W-1:0]    rd_nib,
  output logic [ADDR_W-1:0]   cur_addr,
  output logic                ram_we,
  output logic [NIB_W-1:0]    ram_wdata,
  output logic                data_phase,
  output logic                sdata_out,
  output logic                sdata_oe,
  output logic                cmd_stb,
  output logic [CMD_BITS-1:0] cmd_word
);
  localparam int CNT_W = $clog2(CMD_BITS + 1);
  localparam int NIB_IDX_W = (NIB_W > 1) ? $clog2(NIB_W) : 1;

  phase_t              phase;
  logic                mode_rd;
  logic [CNT_W-1:0]    cnt;
  logic [NIB_IDX_W-1:0] rd_cnt;
  logic [CMD_BITS-1:0] shreg;
  logic [NIB_W-1:0]    nib;
  logic [MODE_BITS-1:0] id_now;
  logic                nib_last;

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a);
    if (a == ADDR_W'(DEPTH - 1) || a == '1) return '0;
    return a + ADDR_W'(1);
  endfunction

  assign id_now     = {shreg[MODE_BITS-2:0], din};
  assign nib_last   = (cnt == CNT_W'(NIB_W - 1));
  assign data_phase = (phase == PH_DATA);
  assign ram_we     = sel_act && wr_rise && data_phase && !mode_rd && nib_last;
  assign ram_wdata  = {din, nib[NIB_W-2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_ID;
      mode_rd   <= 1'b0;
      cnt       <= '0;
      rd_cnt    <= '0;
      shreg     <= '0;
      nib       <= '0;
      cur_addr  <= '0;
      sdata_out <= 1'b0;
      sdata_oe  <= 1'b0;
      cmd_stb   <= 1'b0;
      cmd_word  <= '0;
    end else begin
      cmd_stb <= 1'b0;
      if (!sel_act) begin
        phase    <= PH_ID;
        cnt      <= '0;
        rd_cnt   <= '0;
        sdata_oe <= 1'b0;
      end else begin
        if (wr_edge && !rd_fall) sdata_oe <= 1'b0;
        if (wr_rise) begin
          unique case (phase)
            PH_ID: begin
              shreg <= {shreg[CMD_BITS-2:0], din};
              if (cnt == CNT_W'(MODE_BITS - 1)) begin
                cnt <= '0;
                if (id_now == MODE_RD) begin
                  phase <= PH_ADDR; mode_rd <= 1'b1;
                end else if (id_now == MODE_WR) begin
                  phase <= PH_ADDR; mode_rd <= 1'b0;
                end else if (id_now == MODE_CMD) begin
                  phase <= PH_CMD;
                end else begin
                  phase <= PH_DEAD;
                end
              end else begin
                cnt <= cnt + CNT_W'(1);
              end
            end
            PH_ADDR: begin
              shreg <= {shreg[CMD_BITS-2:0], din};
              if (cnt == CNT_W'(ADDR_W - 1)) begin
                cur_addr <= {shreg[ADDR_W-2:0], din};
                cnt      <= '0;
                rd_cnt   <= '0;
                phase    <= PH_DATA;
              end else begin
                cnt <= cnt + CNT_W'(1);
              end
            end
            PH_DATA: begin
              if (!mode_rd) begin
                nib[cnt[NIB_IDX_W-1:0]] <= din;
                if (nib_last) begin
                  cnt      <= '0;
                  rd_cnt   <= '0;
                  cur_addr <= step(cur_addr);
                end else begin
                  cnt <= cnt + CNT_W'(1);
                end
              end
            end
            PH_CMD: begin
              shreg <= {shreg[CMD_BITS-2:0], din};
              if (cnt == CNT_W'(CMD_BITS - 1)) begin
                cnt      <= '0;
                cmd_stb  <= 1'b1;
                cmd_word <= {shreg[CMD_BITS-2:0], din};
              end else begin
                cnt <= cnt + CNT_W'(1);
              end
            end
            default: ;
          endcase
        end
        if (rd_fall && data_phase) begin
          sdata_out <= rd_nib[rd_cnt];
          sdata_oe  <= 1'b1;
          if (rd_cnt == NIB_IDX_W'(NIB_W - 1)) begin
            rd_cnt <= '0;
            if (mode_rd) cur_addr <= step(cur_addr);
          end else begin
            rd_cnt <= rd_cnt + NIB_IDX_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/lcdsi_cmd_decode.sv
module lcdsi_cmd_decode
  import lcdsi_pkg::*;
(
  input  logic                stb,
  input  logic [CMD_BITS-1:0] word,
  output cmd_evt_t            evt,
  output logic [1:0]          com_code,
  output logic                bias_third,
  output logic [2:0]          rate_code
);
  cmd_evt_t raw;
  assign raw        = classify(word);
  assign evt        = stb ? raw : '0;
  assign com_code   = word[4:3];
  assign bias_third = word[1];
  assign rate_code  = word[3:1];
endmodule

// File: rtl/lcd_serial_slave.sv
module lcd_serial_slave
  import lcdsi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DEPTH = 32,
  parameter int NIB_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_n,
  input  logic                wclk,
  input  logic                rclk,
  input  logic                sdin,
  output logic                sdata_out,
  output logic                sdata_oe,
  input  logic [ADDR_W-1:0]   scan_addr,
  output logic [NIB_W-1:0]    scan_data,
  output logic                cmd_stb,
  output logic [CMD_BITS-1:0] cmd_word,
  output logic                evt_sys_off,
  output logic                evt_sys_on,
  output logic                evt_lcd_off,
  output logic                evt_lcd_on,
  output logic                evt_tone_off,
  output logic                evt_tone_on,
  output logic                evt_bias,
  output logic                evt_rate,
  output logic [1:0]          com_code,
  output logic                bias_third,
  output logic [2:0]          rate_code
);
  localparam int PIN_N = 4;
  localparam int P_SEL = 0, P_WR = 1, P_RD = 2, P_DIN = 3;

  logic [PIN_N-1:0] pin_lvl, pin_rise, pin_fall;
  logic sel_act, wr_rise, wr_edge, rd_fall, din_s;
  logic data_phase, ram_we;
  logic [ADDR_W-1:0] cur_addr;
  logic [NIB_W-1:0] rd_nib, ram_wdata;
  cmd_evt_t evt;

  lcdsi_pin_sync #(
    .W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(4'b0111)
  ) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pins({sdin, rclk, wclk, sel_n}),
    .lvl(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  assign sel_act = ~pin_lvl[P_SEL];
  assign wr_rise = pin_rise[P_WR];
  assign wr_edge = pin_rise[P_WR] | pin_fall[P_WR];
  assign rd_fall = pin_fall[P_RD];
  assign din_s   = pin_lvl[P_DIN];

  lcdsi_engine #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .NIB_W(NIB_W)
  ) u_engine (
    .clk(clk), .rst_n(rst_n),
    .sel_act(sel_act), .din(din_s),
    .wr_rise(wr_rise), .wr_edge(wr_edge), .rd_fall(rd_fall),
    .rd_nib(rd_nib), .cur_addr(cur_addr),
    .ram_we(ram_we), .ram_wdata(ram_wdata),
    .data_phase(data_phase),
    .sdata_out(sdata_out), .sdata_oe(sdata_oe),
    .cmd_stb(cmd_stb), .cmd_word(cmd_word)
  );

  lcdsi_ram #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .NIB_W(NIB_W)
  ) u_ram (
    .clk(clk), .rst_n(rst_n),
    .we(ram_we), .waddr(cur_addr), .wdata(ram_wdata),
    .raddr_a(cur_addr), .rdata_a(rd_nib),
    .raddr_b(scan_addr), .rdata_b(scan_data)
  );

  lcdsi_cmd_decode u_dec (
    .stb(cmd_stb), .word(cmd_word), .evt(evt),
    .com_code(com_code), .bias_third(bias_third), .rate_code(rate_code)
  );

  assign evt_sys_off  = evt.sys_off;
  assign evt_sys_on   = evt.sys_on;
  assign evt_lcd_off  = evt.lcd_off;
  assign evt_lcd_on   = evt.lcd_on;
  assign evt_tone_off = evt.tone_off;
  assign evt_tone_on  = evt.tone_on;
  assign evt_bias     = evt.bias;
  assign evt_rate     = evt.rate;
endmodule

// File: rtl/lcd_serial_slave_chk.sv
module lcd_serial_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_act,
  input logic       wr_rise,
  input logic       wr_edge,
  input logic       rd_fall,
  input logic       data_phase,
  input logic       sdata_oe,
  input logic       cmd_stb,
  input logic [7:0] evts
);
  // R11
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_act |=> !sdata_oe);
  // R11
  oe_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_act && rd_fall && data_phase) |=> sdata_oe);
  // R11
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_act && wr_edge && !rd_fall) |=> !sdata_oe);
  // R8
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);
  // R8
  stb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(wr_rise && sel_act));
  // R9
  evt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evts));
  // R9
  evt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_stb |-> (evts == 8'h00));
endmodule

bind lcd_serial_slave lcd_serial_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_act(sel_act), .wr_rise(wr_rise),
  .wr_edge(wr_edge), .rd_fall(rd_fall), .data_phase(data_phase),
  .sdata_oe(sdata_oe), .cmd_stb(cmd_stb),
  .evts({evt_sys_off, evt_sys_on, evt_lcd_off, evt_lcd_on,
         evt_tone_off, evt_tone_on, evt_bias, evt_rate})
);

// File: tb/lcd_serial_slave_bench.sv
module lcd_serial_slave_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, wclk = 1'b1, rclk = 1'b1, sdin = 1'b0;
  logic [5:0] scan_addr = '0;
  logic sdata_out, sdata_oe, cmd_stb;
  logic [3:0] scan_data;
  logic [8:0] cmd_word;
  logic e_soff, e_son, e_loff, e_lon, e_toff, e_ton, e_bias, e_rate;
  logic [1:0] com_code;
  logic bias_third;
  logic [2:0] rate_code;

  int n_checks = 0;
  int n_errors = 0;
  logic [3:0] model [64];
  logic [8:0] exp_q [$];

  always #2 clk = ~clk;

  lcd_serial_slave u_lcd_serial_slave (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wclk(wclk), .rclk(rclk),
    .sdin(sdin), .sdata_out(sdata_out), .sdata_oe(sdata_oe),
    .scan_addr(scan_addr), .scan_data(scan_data),
    .cmd_stb(cmd_stb), .cmd_word(cmd_word),
    .evt_sys_off(e_soff), .evt_sys_on(e_son), .evt_lcd_off(e_loff),
    .evt_lcd_on(e_lon), .evt_tone_off(e_toff), .evt_tone_on(e_ton),
    .evt_bias(e_bias), .evt_rate(e_rate),
    .com_code(com_code), .bias_third(bias_third), .rate_code(rate_code)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_sess();
    sel_n = 1'b0; idle(4);
  endtask

  task automatic end_sess();
    sel_n = 1'b1; idle(6);
  endtask

  task automatic wbit(input logic b);
    sdin = b; wclk = 1'b0; idle(5); wclk = 1'b1; idle(5);
  endtask

  task automatic wmsb(input int v, input int n);
    for (int i = n - 1; i >= 0; i--) wbit(v[i]);
  endtask

  function automatic int nxt(input int a);
    return (a == 31 || a == 63) ? 0 : a + 1;
  endfunction

  // write nibble LSB first and update the model
  task automatic wnib(inout int a, input logic [3:0] v);
    for (int i = 0; i < 4; i++) wbit(v[i]);
    if (a < 32) model[a] = v;
    a = nxt(a);
  endtask

  task automatic rnib(input string tag, input logic [3:0] exp);
    logic [3:0] got;
    for (int i = 0; i < 4; i++) begin
      rclk = 1'b0; idle(5);
      got[i] = sdata_out;
      check(sdata_oe === 1'b1, {tag, " R11 drive"}, int'(sdata_oe), 1);
      rclk = 1'b1; idle(5);
    end
    check(got === exp, tag, int'(got), int'(exp));
  endtask

  task automatic scan(input int a, input string tag);
    logic [3:0] exp;
    exp = (a < 32) ? model[a] : 4'h0;
    scan_addr = 6'(a); idle(1);
    check(scan_data === exp, tag, int'(scan_data), int'(exp));
  endtask

  task automatic send_cmd(input logic [8:0] w);
    exp_q.push_back(w);
    wmsb(int'(w), 9);
  endtask

  function automatic logic [7:0] expect_evt(input logic [8:0] w);
    casez (w)
      9'b0000_0000_?: return 8'b1000_0000;
      9'b0000_0001_?: return 8'b0100_0000;
      9'b0000_0010_?: return 8'b0010_0000;
      9'b0000_0011_?: return 8'b0001_0000;
      9'b0000_1000_?: return 8'b0000_1000;
      9'b0000_1001_?: return 8'b0000_0100;
      9'b0010_?????:  return 8'b0000_0010;
      9'b101??????:   return 8'b0000_0001;
      default:        return 8'b0;
    endcase
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && cmd_stb) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected strobe", int'(cmd_word), -1);
      end else begin
        logic [8:0] w;
        logic [7:0] ev;
        w = exp_q.pop_front();
        ev = expect_evt(w);
        check(cmd_word === w, "R8 word", int'(cmd_word), int'(w));
        check({e_soff, e_son, e_loff, e_lon, e_toff, e_ton, e_bias, e_rate} === ev,
              "R9 events",
              int'({e_soff, e_son, e_loff, e_lon, e_toff, e_ton, e_bias, e_rate}),
              int'(ev));
        if (ev[1]) check({com_code, bias_third} === {w[4:3], w[1]}, "R9 bias fields",
                         int'({com_code, bias_third}), int'({w[4:3], w[1]}));
        if (ev[0]) check(rate_code === w[3:1], "R9 rate field",
                         int'(rate_code), int'(w[3:1]));
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    int a;
    for (int i = 0; i < 64; i++) model[i] = 4'h0;
    idle(3); rst_n = 1'b1; idle(4);

    // R12 reset state
    check(sdata_oe === 1'b0, "R11 oe after reset", int'(sdata_oe), 0);
    check(cmd_stb === 1'b0, "R8 no strobe after reset", int'(cmd_stb), 0);
    scan(0, "R12 reset zero 0"); scan(17, "R12 reset zero 17");

    // R3 R2 write burst at 5
    begin_sess(); wmsb(3'b101, 3); wmsb(5, 6);
    a = 5; wnib(a, 4'hA); wnib(a, 4'h3); wnib(a, 4'hC);
    end_sess();
    scan(5, "R3 nibble at 5"); scan(6, "R4 next address 6"); scan(7, "R4 address 7");

    // R4 wrap 31 to 0
    begin_sess(); wmsb(3'b101, 3); wmsb(31, 6);
    a = 31; wnib(a, 4'h9); wnib(a, 4'h6);
    end_sess();
    scan(31, "R4 nibble at 31"); scan(0, "R4 wrap to 0");

    // R6 read mode
    begin_sess(); wmsb(3'b110, 3); wmsb(5, 6);
    check(sdata_oe === 1'b0, "R11 no drive before read strobe", int'(sdata_oe), 0);
    rnib("R6 read 5", model[5]); rnib("R6 read 6", model[6]); rnib("R6 read 7", model[7]);
    end_sess();
    check(sdata_oe === 1'b0, "R11 release on deselect", int'(sdata_oe), 0);

    // R5 out of range
    begin_sess(); wmsb(3'b101, 3); wmsb(40, 6);
    a = 40; wnib(a, 4'hF); wnib(a, 4'hE);
    end_sess();
    scan(40, "R5 reads zero 40"); scan(8, "R5 alias 8 untouched"); scan(9, "R5 alias 9 untouched");
    begin_sess(); wmsb(3'b110, 3); wmsb(63, 6);
    rnib("R5 read 63 zero", 4'h0); rnib("R4 read after 63 wraps to 0", model[0]);
    end_sess();

    // R7 read-modify-write
    begin_sess(); wmsb(3'b101, 3); wmsb(6, 6);
    a = 6;
    rnib("R7 read before modify 6", model[6]);
    wbit(1'b1);
    check(sdata_oe === 1'b0, "R11 release on write edge", int'(sdata_oe), 0);
    wbit(1'b0); wbit(1'b1); wbit(1'b0);
    model[6] = 4'h5; a = nxt(a);
    rnib("R7 read before modify 7", model[7]);
    wnib(a, 4'h1);
    end_sess();
    scan(6, "R7 modified 6"); scan(7, "R7 modified 7"); scan(8, "R7 address 8 untouched");

    // R8 R9 command chain
    begin_sess(); wmsb(3'b100, 3);
    send_cmd(9'b0_0000_0010); send_cmd(9'b0_0000_0111); send_cmd(9'b0_0001_0011);
    send_cmd(9'b0_0101_0010); send_cmd(9'b1_0100_0110); send_cmd(9'b0_0000_0001);
    send_cmd(9'b0_0000_0100); send_cmd(9'b0_0001_0000); send_cmd(9'b1_1100_0000);
    send_cmd(9'b0_0100_1000);
    idle(4);
    end_sess();
    check(exp_q.size() == 0, "R8 all words seen", exp_q.size(), 0);

    // R10 abort mid nibble and mid command
    begin_sess(); wmsb(3'b101, 3); wmsb(10, 6); wbit(1'b1); wbit(1'b1);
    end_sess();
    scan(10, "R10 partial nibble dropped");
    begin_sess(); wmsb(3'b100, 3); wmsb(5'b10101, 5);
    end_sess();
    begin_sess(); wmsb(3'b100, 3); send_cmd(9'b0_0001_0010); idle(4);
    end_sess();
    check(exp_q.size() == 0, "R10 fresh mode code after abort", exp_q.size(), 0);

    // R1 unknown codes ignored
    begin_sess(); wmsb(3'b111, 3); wmsb(3, 6); a = 3; wnib(a, 4'hF); model[3] = 4'h0;
    wmsb(9'b0_0000_0010, 9);
    end_sess();
    scan(3, "R1 code 111 ignored");
    begin_sess(); wmsb(3'b010, 3); wmsb(9'b0_0000_0011, 9); wmsb(9'b0_0000_0011, 9);
    end_sess();
    check(exp_q.size() == 0, "R1 code 010 no command", exp_q.size(), 0);
    scan(5, "R1 memory intact 5");

    // R2 levels without rising edge capture nothing
    begin_sess(); wmsb(3'b101, 3); wmsb(12, 6);
    sdin = 1'b1; idle(8); sdin = 1'b0; idle(8);
    end_sess();
    scan(12, "R2 no capture without edge");

    summary();
    $finish;
  end
endmodule